// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned operands and an incoming carry. It returns the sum and the carry out of the top bit, with no clock in the path. The operand is cut into groups, and each group is wider than the one below it. Every group above the lowest one runs two short ripple chains side by side. One chain assumes a carry-in of 0 and the other assumes 1. Both chains settle while the lower groups are still resolving.

When the true carry reaches a group, it drives a 2:1 selector. The selector picks that group's sum bits and its carry-out from one of the two chains. The chosen carry-out then becomes the select for the next group up. The lowest group has no earlier group to wait for, so it ripples directly from the block's carry-in.

The group widths are held in a parameter, one 8-bit field per group, with the lowest group in the low field. The default is 2, 3, 4, 5 and 6 bits, which gives 20 bits in total. Elaboration stops with an error if the widths do not add up to the operand width.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `{carryOut, sumOut}` equals the unsigned value of `opA + opB + carryIn` for every input combination at the default width of 20 bits.
- R2: The default groups span bits [1:0], [4:2], [8:5], [13:9] and [19:14]. A carry that enters any of these groups at its lowest bit is delivered correctly across each group boundary.
- R3: Each selecting group evaluates both carry-in assumptions. Whenever the chain that assumes carry-in 0 produces a carry-out, the chain that assumes carry-in 1 also produces one.
- R4: A group in which every bit propagates (exactly one operand bit set) passes its true carry-in straight to its carry-out.
- R5: A group in which every bit kills (both operand bits clear) gives a carry-out of 0 whatever its carry-in.
- R6: A group whose top bit generates (both operand bits set) gives a carry-out of 1 whatever its carry-in.
- R7: With `opA` all ones, `opB` zero and `carryIn` 1, the carry travels through every group: `sumOut` is zero and `carryOut` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 20 | First operand |
| opB | input | 20 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 20 | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The bench builds the block with its default parameters: 20 bits in five groups of 2, 3, 4, 5 and 6, with the lowest group rippling directly. This setting makes every selector and both chains of every group reachable. Directed carry runs that end at each of the four group boundaries check that the selection hands over correctly. Whole-group propagate, kill and generate patterns check that each selector follows, or ignores, its incoming carry as it should.

// File: rtl/sqrt_csel_pkg.sv
package sqrt_csel_pkg;

  localparam int unsigned SIZE_FIELD = 8;

  // Carry-outs from the two speculative chains of one group.
  typedef struct packed {
    logic assumeZero;
    logic assumeOne;
  } carryPair_t;

  // Sum of the widths of groups 0 .. upto-1 taken from a packed size list.
  function automatic int unsigned sizePrefix(
    input logic [255:0] sizeList,
    input int unsigned  upto
  );
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < upto; k++) begin
      acc += int'(sizeList[k*SIZE_FIELD +: SIZE_FIELD]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);

  logic [W-1:0] genBit;
  logic [W-1:0] propBit;
  logic [W:0]   chain;

  assign genBit   = opA & opB;
  assign propBit  = opA ^ opB;
  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign chain[i+1] = genBit[i] | (propBit[i] & chain[i]);
  end

  assign sumOut   = propBit ^ chain[W-1:0];
  assign carryOut = chain[W];

endmodule

// File: rtl/csel_group.sv
module csel_group
  import sqrt_csel_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carrySel,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);

  logic [W-1:0] sumZero;
  logic [W-1:0] sumOne;
  carryPair_t   pair;

  csel_ripple #(.W(W)) u_chainZero (
    .opA(opA), .opB(opB), .carryIn(1'b0),
    .sumOut(sumZero), .carryOut(pair.assumeZero)
  );

  csel_ripple #(.W(W)) u_chainOne (
    .opA(opA), .opB(opB), .carryIn(1'b1),
    .sumOut(sumOne), .carryOut(pair.assumeOne)
  );

  assign sumOut   = carrySel ? sumOne : sumZero;
  assign carryOut = carrySel ? pair.assumeOne : pair.assumeZero;

  always_comb begin
    // R3: the chain that assumes carry-in 1 never loses a carry that the other keeps
    a_r3_carry_order: assert (!pair.assumeZero || pair.assumeOne)
      else $error("R3 chain order broken");
    // R4: a group that propagates on every bit forwards its carry
    if (&(opA ^ opB))
      a_r4_pass_through: assert (carryOut == carrySel)
        else $error("R4 propagate group");
    // R5: a group that kills on every bit emits no carry
    if (~|(opA | opB))
      a_r5_all_kill: assert (!carryOut)
        else $error("R5 kill group");
    // R6: a generate in the top bit forces a carry
    if (opA[W-1] && opB[W-1])
      a_r6_top_generate: assert (carryOut)
        else $error("R6 generate group");
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqrt_csel_pkg::*;
#(
  parameter int unsigned WIDTH       = 20,
  parameter int unsigned NUM_GROUPS  = 5,
  parameter logic [NUM_GROUPS*8-1:0] GROUP_SIZES = {8'd6, 8'd5, 8'd4, 8'd3, 8'd2},
  parameter bit          FIRST_RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam logic [255:0] SIZE_LIST = 256'(GROUP_SIZES);
  localparam int unsigned  COVERED   = sizePrefix(SIZE_LIST, NUM_GROUPS);

  if (COVERED != WIDTH) begin : g_bad_sizes
    $error("group sizes add to %0d, width is %0d", COVERED, WIDTH);
  end

  logic [NUM_GROUPS:0] groupCarry;
  assign groupCarry[0] = carryIn;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_group
    localparam int unsigned LO = sizePrefix(SIZE_LIST, k);
    localparam int unsigned GW = int'(GROUP_SIZES[k*SIZE_FIELD +: SIZE_FIELD]);

    if (k == 0 && FIRST_RIPPLE) begin : g_plain
      csel_ripple #(.W(GW)) u_lowest (
        .opA(opA[LO +: GW]), .opB(opB[LO +: GW]),
        .carryIn(groupCarry[k]),
        .sumOut(sumOut[LO +: GW]), .carryOut(groupCarry[k+1])
      );
    end else begin : g_select
      csel_group #(.W(GW)) u_sel (
        .opA(opA[LO +: GW]), .opB(opB[LO +: GW]),
        .carrySel(groupCarry[k]),
        .sumOut(sumOut[LO +: GW]), .carryOut(groupCarry[k+1])
      );
    end
  end

  assign carryOut = groupCarry[NUM_GROUPS];

  always_comb begin
    // R1: full result matches unsigned addition
    a_r1_sum_match: assert ({carryOut, sumOut} ==
        ({1'b0, opA} + {1'b0, opB} + (WIDTH+1)'(carryIn)))
      else $error("R1 sum mismatch");
    // R7: carry-in travels through the whole width
    if ((&opA) && (~|opB) && carryIn)
      a_r7_full_chain: assert (carryOut && (~|sumOut))
        else $error("R7 full chain");
  end

endmodule

// File: tb/tb_sqrt_csel_adder.sv
module tb_sqrt_csel_adder;

  localparam int W = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  sqrt_csel_adder dut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic logic [W:0] refAdd(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c, input string req);
    logic [W:0] exp;
    @(negedge clk);
    opA = x; opB = y; carryIn = c;
    #2;
    exp = refAdd(x, y, c);
    applied++;
    if ({carryOut, sumOut} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h c=%b actual=%h expected=%h",
               req, x, y, c, {carryOut, sumOut}, exp);
    end
  endtask

  // Carry-out of the group spanning [hi:lo], checked through the sum bit above it.
  task automatic groupCarryCheck(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic c, input int hi, input logic expCarry,
                                 input string req);
    logic [W:0] full;
    @(negedge clk);
    opA = x; opB = y; carryIn = c;
    #2;
    full = {carryOut, sumOut};
    applied++;
    if (full[hi+1] !== expCarry) begin
      errors++;
      $display("FAIL %s bit %0d actual=%b expected=%b", req, hi+1, full[hi+1], expCarry);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin : stim
    int lo [5] = '{0, 2, 5, 9, 14};
    int hi [5] = '{1, 4, 8, 13, 19};
    void'($urandom(32'd2024));

    // R1: idle inputs give zero
    apply('0, '0, 1'b0, "R1");
    // R7: full-width carry run
    apply('1, '0, 1'b1, "R7");
    apply('0, '1, 1'b1, "R7");
    apply('1, '1, 1'b1, "R1");

    // R2: carries ending at every group boundary
    for (int k = 1; k < 5; k++) begin
      apply(W'((1 << lo[k]) - 1), '0, 1'b1, "R2");
      apply(W'(1 << (lo[k] - 1)), W'(1 << (lo[k] - 1)), 1'b0, "R2");
      apply(W'((1 << lo[k]) - 1), W'(1), 1'b0, "R2");
    end

    for (int k = 1; k < 5; k++) begin
      logic [W-1:0] mask;
      logic [W-1:0] below;
      mask  = W'(((1 << (hi[k] - lo[k] + 1)) - 1) << lo[k]);
      below = W'((1 << lo[k]) - 1);
      // R4: all-propagate group follows the carry from below
      groupCarryCheck(mask | below, '0, 1'b1, hi[k], 1'b1, "R4");
      groupCarryCheck(mask, '0, 1'b1, hi[k], 1'b0, "R4");
      // R5: all-kill group blocks an incoming carry
      groupCarryCheck(below, '0, 1'b1, hi[k], 1'b0, "R5");
      // R6: generate at the group's top bit, with and without carry in
      groupCarryCheck(W'(1 << hi[k]), W'(1 << hi[k]), 1'b0, hi[k], 1'b1, "R6");
      groupCarryCheck(W'(1 << hi[k]) | below, W'(1 << hi[k]), 1'b1, hi[k], 1'b1, "R6");
    end

    // R3: both speculative chains exercised by random operands
    for (int n = 0; n < 4000; n++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "R3");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule